// File: doc/BRIEF.md
# Byte-Accessed Bidirectional Timer Counter

This block is a 16-bit timer counter that counts up or up/down under a small mode controller. A processor reaches it through an 8-bit data bus. The bus has two byte locations. The high-byte location never touches the counter directly. It goes through an 8-bit holding register that is tied to accesses of the low byte. A read of the low byte captures the upper half at the same moment. A write of the low byte commits both halves in one cycle. Every 16-bit transfer is therefore atomic, even while the counter is running.

The counter moves only on cycles where a single-cycle tick pulse arrives and the clock-select field is non-zero. These conditions also apply:

- The top value is an input.
- Status outputs flag when the counter sits at top or at zero.
- A sticky overflow flag forms a level interrupt request.
- An external retrigger input forces the same action the counter takes at top.
- A synchronous clear input zeroes the counter.

Top module: `byte_timer16`

## Requirements
- R1: With `bus_rd` high, `bus_rdata` shows the result of the read in the same cycle, and shows 0 when `bus_rd` is low. Address 0 selects the low byte and address 1 the high byte. A low-byte read returns counter bits 7:0 and, at that clock edge, copies counter bits 15:8 into the holding register. A high-byte read returns the holding register.
- R2: A high-byte write (address 1) loads only the holding register and leaves the counter unchanged. A low-byte write (address 0) loads the counter with {holding register, bus byte} in one cycle.
- R3: A low-byte write takes effect even when clear, retrigger and tick are all active in the same cycle.
- R4: When `clk_sel` is 0, ticks do not change the counter. Bus reads and writes still work.
- R5: When no low-byte write is active, `clear` sets all 16 counter bits to 0 and the count direction to up, whatever tick and retrigger do.
- R6: In wrap mode (`mode`=0), each qualified tick adds one. A tick taken while the counter is at or above `top_val` loads 0 instead and sets the overflow flag.
- R7: In up/down mode (`mode`=1), each qualified tick moves the counter by one. The direction turns to down when the counter is at or above `top_val`, and turns back to up at zero; zero takes priority. The tick that brings the counter down to 0 sets the overflow flag.
- R8: `cnt_top` is high exactly when the counter equals `top_val`. `cnt_bottom` is high exactly when the counter is 0.
- R9: When neither a low-byte write nor clear is active, `retrig` takes precedence over the tick. In wrap mode it loads 0 and sets the overflow flag. In up/down mode it turns the direction to down and leaves the value unchanged.
- R10: `ovf_flag` stays high until a cycle in which `flag_clr` is high and no new overflow event occurs. An overflow event in the same cycle as `flag_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 1 | Byte select: 0 low, 1 high |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, combinational |
| clk_sel | input | 3 | Clock-select field; 0 stops counting |
| tick | input | 1 | Single-cycle count enable pulse |
| mode | input | 1 | 0 wrap, 1 up/down |
| top_val | input | 16 | Current maximum count |
| clear | input | 1 | Synchronous counter clear |
| retrig | input | 1 | External event that forces the top action |
| flag_clr | input | 1 | Overflow flag clear strobe |
| cnt_top | output | 1 | Counter equals top_val |
| cnt_bottom | output | 1 | Counter equals zero |
| ovf_flag | output | 1 | Sticky overflow, level interrupt request |

## Verification
The assertions assume the bus never raises read and write in the same cycle. One of them checks this assumption. The stimulus always chooses at most one bus operation per cycle. The assertions also assume that tick, clear, retrig and flag_clr sit low during reset, and the bench holds them low until reset is released. The top value and mode may change between any two cycles. The stimulus changes them only away from clock edges, so each property sees them as steady over the edge it checks.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef enum logic {
      MODE_WRAP = 1'b0,
      MODE_UPDN = 1'b1
   } bt_mode_e;

   localparam logic ADDR_LO = 1'b0;
   localparam logic ADDR_HI = 1'b1;
endpackage

// File: rtl/bt_byte_port.sv
module bt_byte_port
   import bt_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int CNT_W    = 16,
   parameter bit READ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic             bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0] cnt_q,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic [BUS_W-1:0] bus_rdata
);
   localparam int HI_W = CNT_W - BUS_W;

   logic [HI_W-1:0]  hold_q;
   logic [BUS_W-1:0] rd_mux;
   logic             rd_lo;
   logic             wr_hi;

   assign rd_lo    = bus_rd && (bus_addr == ADDR_LO);
   assign wr_hi    = bus_wr && (bus_addr == ADDR_HI);
   assign load     = bus_wr && (bus_addr == ADDR_LO);
   assign load_val = {hold_q, bus_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (wr_hi) begin
         hold_q <= bus_wdata[HI_W-1:0];
      end else if (rd_lo) begin
         hold_q <= cnt_q[CNT_W-1:BUS_W];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (bus_rd) begin
         if (bus_addr == ADDR_LO) rd_mux = cnt_q[BUS_W-1:0];
         else                     rd_mux = BUS_W'(hold_q);
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         logic [BUS_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_mux;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate

   // R1: a low-byte read captures the upper counter half
   assert_hold_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo && !bus_wr) |=> hold_q == $past(cnt_q[CNT_W-1:BUS_W]));

   // R2: high-byte write reaches the holding register
   assert_hold_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> hold_q == $past(bus_wdata[HI_W-1:0]));

   // R1: input assumption, one bus operation per cycle
   assert_one_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));
endmodule

// File: rtl/bt_count_core.sv
module bt_count_core
   import bt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clear,
   input  logic             retrig,
   input  logic             run,
   input  bt_mode_e         mode,
   input  logic [CNT_W-1:0] top_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_evt,
   output logic             at_top,
   output logic             at_bottom
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_d;
   logic             dn_q;
   logic             dn_d;
   logic             eff_dn;
   logic             past_top;

   assign at_top    = (cnt_q == top_val);
   assign at_bottom = (cnt_q == '0);
   assign past_top  = (cnt_q >= top_val);

   always_comb begin
      if (at_bottom)     eff_dn = 1'b0;
      else if (past_top) eff_dn = 1'b1;
      else               eff_dn = dn_q;
   end

   always_comb begin
      cnt_d   = cnt_q;
      dn_d    = dn_q;
      ovf_evt = 1'b0;
      if (load) begin
         cnt_d = load_val;
      end else if (clear) begin
         cnt_d = '0;
         dn_d  = 1'b0;
      end else if (retrig) begin
         if (mode == MODE_WRAP) begin
            cnt_d   = '0;
            ovf_evt = 1'b1;
         end else begin
            dn_d = 1'b1;
         end
      end else if (run) begin
         if (mode == MODE_WRAP) begin
            if (past_top) begin
               cnt_d   = '0;
               ovf_evt = 1'b1;
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end else begin
            dn_d = eff_dn;
            if (eff_dn) begin
               cnt_d   = cnt_q - ONE;
               ovf_evt = (cnt_q == ONE);
            end else begin
               cnt_d = cnt_q + ONE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dn_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         dn_q  <= dn_d;
      end
   end

   assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt_q == $past(load_val));

   assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !load) |=> cnt_q == '0);

   assert_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load && !clear && !retrig) |=> $stable(cnt_q));

   assert_wrap_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !clear && !retrig && mode == MODE_WRAP && cnt_q < top_val)
      |=> cnt_q == $past(cnt_q) + ONE);

   assert_updn_bottom_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !clear && !retrig && mode == MODE_UPDN && at_bottom)
      |=> cnt_q == ONE);

   assert_retrig_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (retrig && !load && !clear && mode == MODE_UPDN) |=> $stable(cnt_q));
endmodule

// File: rtl/bt_ovf_flag.sv
module bt_ovf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic flag_clr,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (set_evt)  flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assert_flag_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q);

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
   import bt_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int BUS_W    = 8,
   parameter int CS_W     = 3,
   parameter bit READ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic             bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [CS_W-1:0]  clk_sel,
   input  logic             tick,
   input  logic             mode,
   input  logic [CNT_W-1:0] top_val,
   input  logic             clear,
   input  logic             retrig,
   input  logic             flag_clr,
   output logic             cnt_top,
   output logic             cnt_bottom,
   output logic             ovf_flag
);
   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("byte_timer16: CNT_W must be twice BUS_W");
      end
      if (CS_W < 1) begin : g_bad_cs
         $error("byte_timer16: CS_W must be at least 1");
      end
   endgenerate

   logic             load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;
   logic             ovf_evt;
   logic             run;
   bt_mode_e         mode_e;

   assign run    = tick && (clk_sel != '0);
   assign mode_e = bt_mode_e'(mode);

   bt_byte_port #(
      .BUS_W(BUS_W), .CNT_W(CNT_W), .READ_REG(READ_REG)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q),
      .load(load), .load_val(load_val), .bus_rdata(bus_rdata)
   );

   bt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .clear(clear), .retrig(retrig), .run(run), .mode(mode_e),
      .top_val(top_val), .cnt_q(cnt_q), .ovf_evt(ovf_evt),
      .at_top(cnt_top), .at_bottom(cnt_bottom)
   );

   bt_ovf_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_evt(ovf_evt),
      .flag_clr(flag_clr), .flag_q(ovf_flag)
   );
endmodule

// File: tb/tb_byte_timer16.sv
`timescale 1ns/1ps
module tb_byte_timer16;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 0, bus_rd = 0, bus_addr = 0;
   logic [7:0]  bus_wdata = 0;
   logic [7:0]  bus_rdata;
   logic [2:0]  clk_sel = 3'd1;
   logic        tick = 0, mode = 0, clear = 0, retrig = 0, flag_clr = 0;
   logic [15:0] top_val = 16'hFFFF;
   logic        cnt_top, cnt_bottom, ovf_flag;

   int checks = 0;
   int failures = 0;

   // behavioural reference state
   int m_cnt = 0, m_tmp = 0;
   bit m_dn = 0, m_ovf = 0;

   always #5 clk = ~clk;

   byte_timer16 dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .clk_sel(clk_sel), .tick(tick), .mode(mode), .top_val(top_val),
      .clear(clear), .retrig(retrig), .flag_clr(flag_clr),
      .cnt_top(cnt_top), .cnt_bottom(cnt_bottom), .ovf_flag(ovf_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step(input bit w, input bit r, input bit a, input int d,
                             input bit tk, input bit cl, input bit rt, input bit fc);
      bit evt = 0;
      int nxt = m_cnt;
      int tp = top_val;
      bit run = tk && (clk_sel != 0);
      if (w && a == 0) nxt = (m_tmp << 8) | d;
      else if (cl) begin nxt = 0; m_dn = 0; end
      else if (rt) begin
         if (mode == 0) begin nxt = 0; evt = 1; end
         else m_dn = 1;
      end else if (run) begin
         if (mode == 0) begin
            if (m_cnt >= tp) begin nxt = 0; evt = 1; end
            else nxt = m_cnt + 1;
         end else begin
            if (m_cnt == 0) m_dn = 0;
            else if (m_cnt >= tp) m_dn = 1;
            if (m_dn) begin nxt = m_cnt - 1; evt = (nxt == 0); end
            else nxt = (m_cnt + 1) & 16'hFFFF;
         end
      end
      if (w && a == 1) m_tmp = d;
      else if (r && a == 0) m_tmp = (m_cnt >> 8) & 8'hFF;
      if (evt) m_ovf = 1;
      else if (fc) m_ovf = 0;
      m_cnt = nxt;
   endtask

   // one clock: drive at negedge, compare, then let the edge happen
   task automatic cyc(input bit w, input bit r, input bit a, input int d,
                      input bit tk, input bit cl, input bit rt, input bit fc,
                      output int rv);
      int exp_rd;
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d[7:0];
      tick = tk; clear = cl; retrig = rt; flag_clr = fc;
      #1;
      exp_rd = !r ? 0 : (a == 0 ? (m_cnt & 8'hFF) : m_tmp);
      rv = bus_rdata;
      check("R1 rdata", bus_rdata, exp_rd);
      check("R8 cnt_top", cnt_top, (m_cnt == top_val));
      check("R8 cnt_bottom", cnt_bottom, (m_cnt == 0));
      check("R10 ovf_flag", ovf_flag, m_ovf);
      @(posedge clk);
      model_step(w, r, a, d, tk, cl, rt, fc);
      #1;
      bus_wr = 0; bus_rd = 0; tick = 0; clear = 0; retrig = 0; flag_clr = 0;
   endtask

   task automatic idle(input bit tk, input int n);
      int rv;
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tk, 0, 0, 0, rv);
   endtask

   task automatic wr16(input int v);
      int rv;
      cyc(1, 0, 1, (v >> 8) & 8'hFF, 0, 0, 0, 0, rv);
      cyc(1, 0, 0, v & 8'hFF, 0, 0, 0, 0, rv);
   endtask

   task automatic rd16(output int v);
      int lo, hi;
      cyc(0, 1, 0, 0, 0, 0, 0, 0, lo);
      cyc(0, 1, 1, 0, 0, 0, 0, 0, hi);
      v = (hi << 8) | lo;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int v, rv;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd16(v); check("R1 reset value", v, 0);
      check("R8 reset bottom", cnt_bottom, 1);
      check("R10 reset flag", ovf_flag, 0);

      // atomic write then read
      wr16(16'h1234);
      rd16(v); check("R2 write16", v, 16'h1234);
      cyc(1, 0, 1, 8'hAB, 0, 0, 0, 0, rv);
      rd16(v); check("R2 high write leaves counter", v, 16'h1234);

      // stopped clock select
      clk_sel = 3'd0;
      idle(1, 5);
      rd16(v); check("R4 stopped", v, 16'h1234);
      wr16(16'h0005);
      rd16(v); check("R4 write while stopped", v, 16'h0005);

      // wrap mode
      clk_sel = 3'd1; mode = 0; top_val = 16'd7;
      idle(1, 2);
      check("R8 top reached", cnt_top, 1);
      check("R6 no flag before wrap", ovf_flag, 0);
      idle(1, 1);
      check("R6 wrapped bottom", cnt_bottom, 1);
      check("R6 flag after wrap", ovf_flag, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, rv);
      check("R10 flag cleared", ovf_flag, 0);
      wr16(16'd7);
      cyc(0, 0, 0, 0, 1, 0, 0, 1, rv);
      check("R10 set beats clear", ovf_flag, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, rv);

      // up/down mode
      mode = 1; top_val = 16'd3;
      cyc(0, 0, 0, 0, 0, 1, 0, 0, rv);
      idle(1, 3);
      check("R7 at top", cnt_top, 1);
      idle(1, 2);
      rd16(v); check("R7 coming down", v, 1);
      check("R7 no flag yet", ovf_flag, 0);
      idle(1, 1);
      check("R7 bottom flag", ovf_flag, 1);
      idle(1, 1);
      rd16(v); check("R7 up again", v, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, rv);

      // clear beats tick
      cyc(0, 0, 0, 0, 1, 1, 0, 0, rv);
      rd16(v); check("R5 clear", v, 0);

      // low write beats clear, retrig and tick
      cyc(1, 0, 1, 8'h22, 0, 0, 0, 0, rv);
      cyc(1, 0, 0, 8'h33, 1, 1, 1, 0, rv);
      rd16(v); check("R3 write priority", v, 16'h2233);

      // retrigger in both modes
      mode = 0; top_val = 16'd100;
      wr16(16'h0010);
      cyc(0, 0, 0, 0, 1, 0, 1, 0, rv);
      rd16(v); check("R9 wrap retrig", v, 0);
      check("R9 wrap retrig flag", ovf_flag, 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, rv);
      mode = 1; top_val = 16'd10;
      cyc(0, 0, 0, 0, 0, 1, 0, 0, rv);
      wr16(16'd5);
      cyc(0, 0, 0, 0, 0, 0, 1, 0, rv);
      rd16(v); check("R9 updn retrig holds", v, 5);
      idle(1, 1);
      rd16(v); check("R9 updn now down", v, 4);

      // mixed traffic against the reference model
      for (int i = 0; i < 4000; i++) begin
         int op = $urandom_range(0, 99);
         bit w = 0, r = 0, a = 0;
         int d = $urandom_range(0, 255);
         if (i % 250 == 0) begin
            mode = $urandom_range(0, 1);
            top_val = ($urandom_range(0, 9) == 0) ? 16'($urandom) : 16'($urandom_range(0, 40));
            clk_sel = ($urandom_range(0, 4) == 0) ? 3'd0 : 3'($urandom_range(1, 7));
         end
         if (op < 8) begin w = 1; a = 0; end
         else if (op < 16) begin w = 1; a = 1; d = $urandom_range(0, 3) == 0 ? d : 0; end
         else if (op < 32) begin r = 1; a = 0; end
         else if (op < 48) begin r = 1; a = 1; end
         cyc(w, r, a, d, $urandom_range(0, 1),
             $urandom_range(0, 49) == 0, $urandom_range(0, 49) == 0,
             $urandom_range(0, 19) == 0, rv);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule